// File: doc/BRIEF.md
# Parallel Move Legality and Address Unit

This block sits beside the instruction decoder of a 16-bit signal-processing core. Each cycle it may receive one decoded instruction word. That word carries an arithmetic operation class and an optional single memory move. The block decides whether the arithmetic part and the move may legally share the word. For a legal move it also presents the data-memory address, raises a read or write strobe, and returns the post-incremented pointer so the address register file can write it back.

A move that loads into the accumulator the arithmetic part writes, or into any portion of that accumulator, is rejected. Compare-type operations have no true destination, so they may load their own accumulator as a whole or its low portion. The pointer advances by one or by an offset register. Only a fixed group of operation classes may carry a move at all. All outputs are registered, one cycle after the request.

Top module: `pmove_agu`

## Requirements
- R1: Outputs are registered. A request with `req_valid_i` high in the cycle before a rising edge produces `rsp_valid_o` high after that edge, with results for that request. Without a request, `rsp_valid_o`, `mem_rd_o` and `mem_wr_o` are low. Reset clears every output to zero.
- R2: Register codes are 0=A, 1=B, 2=A0, 3=A1, 4=A2, 5=B0, 6=B1, 7=B2. A load (`mv_dir_i`=0) whose move register belongs to the same accumulator as `alu_dst_i` is illegal for any non-compare class.
- R3: A load into the other accumulator is legal. A store (`mv_dir_i`=1) of any register is legal for a permitted class, including a store of the operation's own destination.
- R4: Class codes 0 to 16 may carry a move. A move with class 17 to 31 is illegal. A request with no move (`mv_en_i`=0) is legal for every class.
- R5: Classes 14, 15 and 16 are compare-type. With these classes, a load of the destination accumulator as a whole (code 0 or 1) or of its low portion (code 2 or 5) is legal. A load of its middle or extension portion remains illegal.
- R6: `mem_addr_o` equals the pointer value of the request, before any update.
- R7: For a legal move, the updated pointer is the pointer plus one when `upd_mode_i`=0, and the pointer plus `ofs_i` when `upd_mode_i`=1, modulo 2^16.
- R8: `mem_rd_o` is high only for a legal load and `mem_wr_o` only for a legal store. For an illegal request or one with no move, both strobes are low and `ptr_next_o` equals the input pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A decoded instruction is presented |
| alu_class_i | input | 5 | Arithmetic operation class code |
| alu_dst_i | input | 3 | Destination accumulator code of the arithmetic part |
| mv_en_i | input | 1 | The word carries a parallel move |
| mv_dir_i | input | 1 | 0 = memory to register, 1 = register to memory |
| mv_reg_i | input | 3 | Register code moved |
| upd_mode_i | input | 1 | 0 = post-increment by one, 1 = by offset |
| ptr_i | input | 16 | Pointer register value |
| ofs_i | input | 16 | Offset register value |
| rsp_valid_o | output | 1 | Results below belong to a request |
| legal_o | output | 1 | Instruction combination is legal |
| mem_addr_o | output | 16 | Effective data-memory address |
| ptr_next_o | output | 16 | Pointer value for write-back |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |

## Verification
Directed loads into each portion of the destination accumulator show where conflicts are detected. The same loads against the other accumulator show that no false conflicts are raised. Stores of the destination register distinguish a source use from a destination conflict. Loads under the compare classes separate the exempt whole and low portions from the still-forbidden upper portions. Classes just above and far above the permitted range, with and without a move, exercise the class gate, and pointer values near 0xFFFF show the wrap for both update modes. A long run of mixed random requests, sent back to back and with gaps, checks the strobes and pointer against the model. It also confirms the one-cycle timing.

// File: rtl/pmove_pkg.sv
package pmove_pkg;

    typedef enum logic [2:0] {
        RC_A  = 3'd0,
        RC_B  = 3'd1,
        RC_A0 = 3'd2,
        RC_A1 = 3'd3,
        RC_A2 = 3'd4,
        RC_B0 = 3'd5,
        RC_B1 = 3'd6,
        RC_B2 = 3'd7
    } regcode_e;

    typedef enum logic {
        ACC_A = 1'b0,
        ACC_B = 1'b1
    } acc_e;

    // Which accumulator a register code belongs to.
    function automatic acc_e owner_acc(input regcode_e c);
        acc_e r;
        case (c)
            RC_A, RC_A0, RC_A1, RC_A2: r = ACC_A;
            default:                   r = ACC_B;
        endcase
        return r;
    endfunction

    // Whole accumulator or its least-significant portion.
    function automatic logic whole_or_low(input regcode_e c);
        return (c == RC_A) || (c == RC_B) || (c == RC_A0) || (c == RC_B0);
    endfunction

endpackage

// File: rtl/pmove_legal.sv
module pmove_legal
    import pmove_pkg::*;
#(
    parameter int unsigned CLASS_W    = 5,
    parameter int unsigned N_MOVE_OPS = 17,
    parameter int unsigned CMP_FIRST  = 14
) (
    input  logic [CLASS_W-1:0] alu_class,
    input  logic [2:0]         alu_dst,
    input  logic               mv_en,
    input  logic               mv_dir,
    input  logic [2:0]         mv_reg,
    output logic               legal
);

    localparam int unsigned N_CLASS = 1 << CLASS_W;

    logic [N_CLASS-1:0] may_move;
    logic [N_CLASS-1:0] cmp_kind;

    // Per-class capability tables, derived from parameters.
    for (genvar i = 0; i < N_CLASS; i++) begin : g_class
        assign may_move[i] = (i < N_MOVE_OPS);
        assign cmp_kind[i] = (i >= CMP_FIRST) && (i < N_MOVE_OPS);
    end

    regcode_e dst_c;
    regcode_e mv_c;
    logic     same_acc;
    logic     exempt;
    logic     clash;

    always_comb begin
        dst_c    = regcode_e'(alu_dst);
        mv_c     = regcode_e'(mv_reg);
        same_acc = (owner_acc(dst_c) == owner_acc(mv_c));
        exempt   = cmp_kind[alu_class] && whole_or_low(mv_c);
        clash    = !mv_dir && same_acc && !exempt;
        legal    = !mv_en || (may_move[alu_class] && !clash);
    end

endmodule

// File: rtl/pmove_addr.sv
module pmove_addr #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] ofs,
    input  logic          by_ofs,
    input  logic          do_upd,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] ptr_upd
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] step;

    always_comb begin
        step    = by_ofs ? ofs : ONE;
        ea      = ptr;
        ptr_upd = do_upd ? (ptr + step) : ptr;
    end

endmodule

// File: rtl/pmove_agu.sv
module pmove_agu
    import pmove_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned CLASS_W    = 5,
    parameter int unsigned N_MOVE_OPS = 17,
    parameter int unsigned CMP_FIRST  = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic [CLASS_W-1:0] alu_class_i,
    input  logic [2:0]         alu_dst_i,
    input  logic               mv_en_i,
    input  logic               mv_dir_i,
    input  logic [2:0]         mv_reg_i,
    input  logic               upd_mode_i,
    input  logic [AW-1:0]      ptr_i,
    input  logic [AW-1:0]      ofs_i,
    output logic               rsp_valid_o,
    output logic               legal_o,
    output logic [AW-1:0]      mem_addr_o,
    output logic [AW-1:0]      ptr_next_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o
);

    typedef struct packed {
        logic          vld;
        logic          legal;
        logic [AW-1:0] addr;
        logic [AW-1:0] pnext;
        logic          rd;
        logic          wr;
    } rsp_t;

    rsp_t st_d, st_q;

    logic          legal_w;
    logic          go_w;
    logic [AW-1:0] ea_w;
    logic [AW-1:0] pupd_w;

    pmove_legal #(
        .CLASS_W   (CLASS_W),
        .N_MOVE_OPS(N_MOVE_OPS),
        .CMP_FIRST (CMP_FIRST)
    ) legal_i (
        .alu_class(alu_class_i),
        .alu_dst  (alu_dst_i),
        .mv_en    (mv_en_i),
        .mv_dir   (mv_dir_i),
        .mv_reg   (mv_reg_i),
        .legal    (legal_w)
    );

    assign go_w = req_valid_i && mv_en_i && legal_w;

    pmove_addr #(
        .AW(AW)
    ) addr_i (
        .ptr    (ptr_i),
        .ofs    (ofs_i),
        .by_ofs (upd_mode_i),
        .do_upd (go_w),
        .ea     (ea_w),
        .ptr_upd(pupd_w)
    );

    always_comb begin
        st_d       = '0;
        st_d.vld   = req_valid_i;
        if (req_valid_i) begin
            st_d.legal = legal_w;
            st_d.addr  = ea_w;
            st_d.pnext = pupd_w;
            st_d.rd    = go_w && !mv_dir_i;
            st_d.wr    = go_w && mv_dir_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.vld;
    assign legal_o     = st_q.legal;
    assign mem_addr_o  = st_q.addr;
    assign ptr_next_o  = st_q.pnext;
    assign mem_rd_o    = st_q.rd;
    assign mem_wr_o    = st_q.wr;

endmodule

// File: rtl/pmove_agu_chk.sv
module pmove_agu_chk #(
    parameter int unsigned AW         = 16,
    parameter int unsigned CLASS_W    = 5,
    parameter int unsigned N_MOVE_OPS = 17
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid_i,
    input logic [CLASS_W-1:0] alu_class_i,
    input logic               mv_en_i,
    input logic               mv_dir_i,
    input logic [AW-1:0]      ptr_i,
    input logic               rsp_valid_o,
    input logic               legal_o,
    input logic [AW-1:0]      mem_addr_o,
    input logic [AW-1:0]      ptr_next_o,
    input logic               mem_rd_o,
    input logic               mem_wr_o
);

    localparam logic [CLASS_W-1:0] CLS_LIM = CLASS_W'(N_MOVE_OPS);

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o}));

    assert_strobe_needs_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> (legal_o && rsp_valid_o));

    assert_illegal_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !legal_o) |-> (ptr_next_o == mem_addr_o));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && !mem_rd_o && !mem_wr_o));

    assert_class_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mv_en_i && !(alu_class_i < CLS_LIM)) |=> !legal_o);

    assert_store_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mv_en_i && mv_dir_i && (alu_class_i < CLS_LIM)) |=> (legal_o && mem_wr_o));

    assert_addr_is_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (mem_addr_o == $past(ptr_i)));

endmodule

bind pmove_agu pmove_agu_chk #(
    .AW        (AW),
    .CLASS_W   (CLASS_W),
    .N_MOVE_OPS(N_MOVE_OPS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid_i),
    .alu_class_i(alu_class_i),
    .mv_en_i    (mv_en_i),
    .mv_dir_i   (mv_dir_i),
    .ptr_i      (ptr_i),
    .rsp_valid_o(rsp_valid_o),
    .legal_o    (legal_o),
    .mem_addr_o (mem_addr_o),
    .ptr_next_o (ptr_next_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o)
);

// File: tb/pmove_agu_tb_top.sv
module pmove_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [4:0]  alu_class_i = '0;
    logic [2:0]  alu_dst_i = '0;
    logic        mv_en_i = 1'b0;
    logic        mv_dir_i = 1'b0;
    logic [2:0]  mv_reg_i = '0;
    logic        upd_mode_i = 1'b0;
    logic [15:0] ptr_i = '0;
    logic [15:0] ofs_i = '0;
    logic        rsp_valid_o;
    logic        legal_o;
    logic [15:0] mem_addr_o;
    logic [15:0] ptr_next_o;
    logic        mem_rd_o;
    logic        mem_wr_o;

    always #4 clk = ~clk;  // 125 MHz

    pmove_agu dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
        .alu_class_i(alu_class_i), .alu_dst_i(alu_dst_i),
        .mv_en_i(mv_en_i), .mv_dir_i(mv_dir_i), .mv_reg_i(mv_reg_i),
        .upd_mode_i(upd_mode_i), .ptr_i(ptr_i), .ofs_i(ofs_i),
        .rsp_valid_o(rsp_valid_o), .legal_o(legal_o), .mem_addr_o(mem_addr_o),
        .ptr_next_o(ptr_next_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o)
    );

    typedef struct {
        logic        legal;
        logic [15:0] addr;
        logic [15:0] pnext;
        logic        rd;
        logic        wr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Reference model written from the requirements.
    function automatic bit acc_of(input logic [2:0] c);
        return (c == 3'd1) || (c >= 3'd5);
    endfunction

    function automatic exp_t model(input logic [4:0] cls, input logic [2:0] dst,
                                   input logic mv, input logic dir, input logic [2:0] mreg,
                                   input logic mode, input logic [15:0] p, input logic [15:0] o,
                                   input string tag);
        exp_t e;
        bit conflict, exempt, ok;
        exempt   = (cls >= 5'd14) && (cls <= 5'd16) &&
                   (mreg == 3'd0 || mreg == 3'd1 || mreg == 3'd2 || mreg == 3'd5);
        conflict = !dir && (acc_of(mreg) == acc_of(dst)) && !exempt;
        ok       = !mv || ((cls <= 5'd16) && !conflict);
        e.legal  = ok;
        e.addr   = p;
        e.rd     = ok && mv && !dir;
        e.wr     = ok && mv && dir;
        e.pnext  = (ok && mv) ? (mode ? p + o : p + 16'd1) : p;
        e.tag    = tag;
        return e;
    endfunction

    task automatic send(input logic [4:0] cls, input logic [2:0] dst, input logic mv,
                        input logic dir, input logic [2:0] mreg, input logic mode,
                        input logic [15:0] p, input logic [15:0] o, input string tag);
        @(negedge clk);
        req_valid_i = 1'b1;
        alu_class_i = cls; alu_dst_i = dst; mv_en_i = mv; mv_dir_i = dir;
        mv_reg_i = mreg; upd_mode_i = mode; ptr_i = p; ofs_i = o;
        exp_q.push_back(model(cls, dst, mv, dir, mreg, mode, p, o, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid_i = 1'b0;
        mv_en_i = 1'b1;
        ptr_i = 16'hBEEF;
    endtask

    // Monitor: compare each response with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid_o) begin
                n_run++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R1: response without request, got valid=1 expected valid=0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (legal_o !== e.legal || mem_addr_o !== e.addr || ptr_next_o !== e.pnext ||
                        mem_rd_o !== e.rd || mem_wr_o !== e.wr) begin
                        n_fail++;
                        $display("FAIL %s: got legal=%0b addr=%h pnext=%h rd=%0b wr=%0b expected legal=%0b addr=%h pnext=%h rd=%0b wr=%0b",
                                 e.tag, legal_o, mem_addr_o, ptr_next_o, mem_rd_o, mem_wr_o,
                                 e.legal, e.addr, e.pnext, e.rd, e.wr);
                    end
                end
            end else if (exp_q.size() != 0 && !req_valid_i) begin
                // nothing: expectation pending for the next edge only if just pushed
            end
        end
    end

    task automatic check_quiet(input string tag);
        @(negedge clk);
        n_run++;
        if (rsp_valid_o !== 1'b0 || mem_rd_o !== 1'b0 || mem_wr_o !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b rd=%0b wr=%0b expected all 0",
                     tag, rsp_valid_o, mem_rd_o, mem_wr_o);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        n_run++;
        if (rsp_valid_o !== 1'b0 || legal_o !== 1'b0 || mem_addr_o !== 16'h0 ||
            ptr_next_o !== 16'h0 || mem_rd_o !== 1'b0 || mem_wr_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: reset got valid=%0b legal=%0b addr=%h expected zeros",
                     rsp_valid_o, legal_o, mem_addr_o);
        end
        rst_n = 1'b1;

        // R2: loads into own accumulator or its portions
        send(5'd0, 3'd0, 1, 0, 3'd0, 0, 16'h1000, 16'h0004, "R2");
        send(5'd3, 3'd0, 1, 0, 3'd3, 0, 16'h1001, 16'h0004, "R2");
        send(5'd5, 3'd1, 1, 0, 3'd7, 1, 16'h1002, 16'h0004, "R2");
        send(5'd9, 3'd6, 1, 0, 3'd5, 1, 16'h1003, 16'h0004, "R2");
        // R3: other accumulator, stores of own destination
        send(5'd0, 3'd0, 1, 0, 3'd1, 0, 16'h2000, 16'h0000, "R3");
        send(5'd2, 3'd0, 1, 1, 3'd0, 1, 16'h2000, 16'h0010, "R3");
        send(5'd8, 3'd1, 1, 1, 3'd6, 0, 16'h2100, 16'h0000, "R3");
        // R4: class gate
        send(5'd17, 3'd0, 1, 1, 3'd1, 0, 16'h3000, 16'h0000, "R4");
        send(5'd31, 3'd0, 1, 0, 3'd1, 0, 16'h3001, 16'h0000, "R4");
        send(5'd16, 3'd0, 1, 1, 3'd1, 0, 16'h3002, 16'h0000, "R4");
        send(5'd20, 3'd0, 0, 0, 3'd0, 1, 16'h3003, 16'h0005, "R4");
        // R5: compare exemption
        send(5'd15, 3'd0, 1, 0, 3'd0, 0, 16'h4000, 16'h0000, "R5");
        send(5'd14, 3'd0, 1, 0, 3'd2, 0, 16'h4001, 16'h0000, "R5");
        send(5'd15, 3'd0, 1, 0, 3'd3, 0, 16'h4002, 16'h0000, "R5");
        send(5'd16, 3'd1, 1, 0, 3'd7, 0, 16'h4003, 16'h0000, "R5");
        send(5'd16, 3'd1, 1, 0, 3'd5, 0, 16'h4004, 16'h0000, "R5");
        send(5'd13, 3'd1, 1, 0, 3'd1, 0, 16'h4005, 16'h0000, "R5");
        // R6 / R7: address and wrap
        send(5'd1, 3'd0, 1, 0, 3'd6, 0, 16'hFFFF, 16'h0000, "R7");
        send(5'd1, 3'd0, 1, 0, 3'd6, 1, 16'hFFF0, 16'h0020, "R7");
        send(5'd1, 3'd1, 1, 1, 3'd2, 1, 16'h1234, 16'hFFFF, "R6");
        // R1: gap in requests
        idle();
        check_quiet("R1");
        send(5'd4, 3'd0, 1, 0, 3'd7, 0, 16'h5555, 16'h0000, "R1");
        idle();
        check_quiet("R1");
        // R8: random mix
        for (int i = 0; i < 400; i++) begin
            logic [4:0]  c = 5'($urandom_range(0, 20));
            logic [2:0]  d = 3'($urandom);
            logic [2:0]  m = 3'($urandom);
            logic [15:0] p = 16'($urandom);
            logic [15:0] o = 16'($urandom);
            send(c, d, 1'($urandom), 1'($urandom), m, 1'($urandom), p, o, "R8");
            if (i % 17 == 0) idle();
        end
        idle();
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: got %0d unanswered requests expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule